// File: doc/BRIEF.md
# DES Round Coprocessor

This block is a DES datapath that a host processor steps through one operation at a time. The host writes a 64-bit key and a 64-bit data block, each as two 32-bit words. It then issues sixteen round operations and reads the 64-bit result back as two 32-bit words. The block has no round counter and no sequencer. Each round operation carries its own direction flag and rotation amount, so the host software decides the order of rounds and the shift schedule. The host encrypts or decrypts simply by changing the flags it sends.

Every operation is presented with a single-cycle valid strobe and an opcode. Key and data loads apply the standard input permutations. A round performs one Feistel step and one key-schedule step in the same cycle. A read returns one half of the final-permuted block on a registered output one cycle later. ECB use is direct. Chaining modes and triple encryption are built in software from repeated sequences.

Top module: `des_round_unit`

## Requirements
- R1: A synchronous reset clears the data halves, the key halves and the result register. The result reads 0 after reset, and a readout issued before any load returns 0 for both words.
- R2: Opcode 2'b00 loads the key. The key is {op_a, op_b}, with op_a as the high word. Permuted choice 1 is applied and the result splits into two 28-bit halves. The data halves are not changed.
- R3: Opcode 2'b01 loads the block {op_a, op_b}, with op_a as the high word. The initial permutation is applied, the upper 32 bits become the left half and the lower 32 bits become the right half.
- R4: Opcode 2'b10 performs one round in a single cycle. The new left half is the old right half. The new right half is the old left half XOR P(S(E(right) XOR round key)).
- R5: In a round with op_a[0]=0 (encrypt), both key halves rotate left by 1 (op_a[1]=0) or by 2 (op_a[1]=1). The round key is permuted choice 2 of the rotated halves.
- R6: In a round with op_a[0]=1 (decrypt), the round key is permuted choice 2 of the current halves. Both halves then rotate right by 1 or 2, as op_a[1] selects. The reversed shift schedule therefore undoes an encryption.
- R7: Opcode 2'b11 reads the result. The block {right, left} passes through the final permutation. The high word is returned when op_a[0]=1 and the low word when op_a[0]=0. The word appears on result_o one cycle after the read.
- R8: A cycle with valid_i low changes no state, whatever the opcode and operands are.
- R9: result_o holds its value across every operation other than a read.
- R10: Sixteen round operations issued on back-to-back cycles give the standard DES result. With key 133457799BBCDFF1 and plaintext 0123456789ABCDEF the result is 85E813540F0AB405.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| valid_i | input | 1 | Operation strobe, one per cycle |
| opc_i | input | 2 | Opcode: 00 key, 01 data, 10 round, 11 read |
| op_a_i | input | 32 | High word for loads; round flags [1:0]; read select [0] |
| op_b_i | input | 32 | Low word for loads |
| result_o | output | 32 | Registered readout word |

## Verification
The round path is checked against four known answers:
- the published key/plaintext pair,
- an all-zero key and block, which exposes any table entry that is wrongly indexed at index zero,
- a weak key with a plaintext that maps to a single set bit,
- decryption of each ciphertext back to its plaintext.

Decryption fails unless the right-rotation order of R6 is exactly the inverse of the left-rotation order. A read before any load shows that reset cleared all state. Strobe-low cycles that carry round opcodes in the middle of a sequence show that nothing advances without valid. Key and data loads issued after a read show that the result word is held.

// File: rtl/des_pkg.sv
package des_pkg;

   localparam int BLK_W  = 64;
   localparam int HALF_W = 32;
   localparam int KH_W   = 28;
   localparam int RK_W   = 48;

   typedef enum logic [1:0] {
      OP_KEY   = 2'b00,
      OP_DATA  = 2'b01,
      OP_ROUND = 2'b10,
      OP_READ  = 2'b11
   } op_e;

   // Position tables: entry i names the 1-based source bit (MSB = 1) of output bit i.
   localparam int IP_TAB [64] = '{
      58,50,42,34,26,18,10,2, 60,52,44,36,28,20,12,4,
      62,54,46,38,30,22,14,6, 64,56,48,40,32,24,16,8,
      57,49,41,33,25,17,9,1,  59,51,43,35,27,19,11,3,
      61,53,45,37,29,21,13,5, 63,55,47,39,31,23,15,7};

   localparam int FP_TAB [64] = '{
      40,8,48,16,56,24,64,32, 39,7,47,15,55,23,63,31,
      38,6,46,14,54,22,62,30, 37,5,45,13,53,21,61,29,
      36,4,44,12,52,20,60,28, 35,3,43,11,51,19,59,27,
      34,2,42,10,50,18,58,26, 33,1,41,9,49,17,57,25};

   localparam int E_TAB [48] = '{
      32,1,2,3,4,5,     4,5,6,7,8,9,      8,9,10,11,12,13,   12,13,14,15,16,17,
      16,17,18,19,20,21, 20,21,22,23,24,25, 24,25,26,27,28,29, 28,29,30,31,32,1};

   localparam int P_TAB [32] = '{
      16,7,20,21,29,12,28,17, 1,15,23,26,5,18,31,10,
      2,8,24,14,32,27,3,9,    19,13,30,6,22,11,4,25};

   localparam int PC1_TAB [56] = '{
      57,49,41,33,25,17,9,  1,58,50,42,34,26,18,
      10,2,59,51,43,35,27,  19,11,3,60,52,44,36,
      63,55,47,39,31,23,15, 7,62,54,46,38,30,22,
      14,6,61,53,45,37,29,  21,13,5,28,20,12,4};

   localparam int PC2_TAB [48] = '{
      14,17,11,24,1,5,   3,28,15,6,21,10,   23,19,12,4,26,8,   16,7,27,20,13,2,
      41,52,31,37,47,55, 30,40,51,45,33,48, 44,49,39,56,34,53, 46,42,50,36,29,32};

   // Substitution boxes, index = row*16 + column.
   localparam int SB1 [64] = '{
      14,4,13,1,2,15,11,8,3,10,6,12,5,9,0,7,  0,15,7,4,14,2,13,1,10,6,12,11,9,5,3,8,
      4,1,14,8,13,6,2,11,15,12,9,7,3,10,5,0,  15,12,8,2,4,9,1,7,5,11,3,14,10,0,6,13};
   localparam int SB2 [64] = '{
      15,1,8,14,6,11,3,4,9,7,2,13,12,0,5,10,  3,13,4,7,15,2,8,14,12,0,1,10,6,9,11,5,
      0,14,7,11,10,4,13,1,5,8,12,6,9,3,2,15,  13,8,10,1,3,15,4,2,11,6,7,12,0,5,14,9};
   localparam int SB3 [64] = '{
      10,0,9,14,6,3,15,5,1,13,12,7,11,4,2,8,  13,7,0,9,3,4,6,10,2,8,5,14,12,11,15,1,
      13,6,4,9,8,15,3,0,11,1,2,12,5,10,14,7,  1,10,13,0,6,9,8,7,4,15,14,3,11,5,2,12};
   localparam int SB4 [64] = '{
      7,13,14,3,0,6,9,10,1,2,8,5,11,12,4,15,  13,8,11,5,6,15,0,3,4,7,2,12,1,10,14,9,
      10,6,9,0,12,11,7,13,15,1,3,14,5,2,8,4,  3,15,0,6,10,1,13,8,9,4,5,11,12,7,2,14};
   localparam int SB5 [64] = '{
      2,12,4,1,7,10,11,6,8,5,3,15,13,0,14,9,  14,11,2,12,4,7,13,1,5,0,15,10,3,9,8,6,
      4,2,1,11,10,13,7,8,15,9,12,5,6,3,0,14,  11,8,12,7,1,14,2,13,6,15,0,9,10,4,5,3};
   localparam int SB6 [64] = '{
      12,1,10,15,9,2,6,8,0,13,3,4,14,7,5,11,  10,15,4,2,7,12,9,5,6,1,13,14,0,11,3,8,
      9,14,15,5,2,8,12,3,7,0,4,10,1,13,11,6,  4,3,2,12,9,5,15,10,11,14,1,7,6,0,8,13};
   localparam int SB7 [64] = '{
      4,11,2,14,15,0,8,13,3,12,9,7,5,10,6,1,  13,0,11,7,4,9,1,10,14,3,5,12,2,15,8,6,
      1,4,11,13,12,3,7,14,10,15,6,8,0,5,9,2,  6,11,13,8,1,4,10,7,9,5,0,15,14,2,3,12};
   localparam int SB8 [64] = '{
      13,2,8,4,6,15,11,1,10,9,3,14,5,0,12,7,  1,15,13,8,10,3,7,4,12,5,6,11,0,14,9,2,
      7,11,4,1,9,12,14,2,0,6,10,13,15,3,5,8,  2,1,14,7,4,10,8,13,15,12,9,0,3,5,6,11};

   function automatic logic [63:0] perm_ip(input logic [63:0] x);
      logic [63:0] y;
      for (int i = 0; i < 64; i++) y[63-i] = x[64-IP_TAB[i]];
      return y;
   endfunction

   function automatic logic [63:0] perm_fp(input logic [63:0] x);
      logic [63:0] y;
      for (int i = 0; i < 64; i++) y[63-i] = x[64-FP_TAB[i]];
      return y;
   endfunction

   function automatic logic [47:0] perm_e(input logic [31:0] x);
      logic [47:0] y;
      for (int i = 0; i < 48; i++) y[47-i] = x[32-E_TAB[i]];
      return y;
   endfunction

   function automatic logic [31:0] perm_p(input logic [31:0] x);
      logic [31:0] y;
      for (int i = 0; i < 32; i++) y[31-i] = x[32-P_TAB[i]];
      return y;
   endfunction

   function automatic logic [55:0] perm_pc1(input logic [63:0] x);
      logic [55:0] y;
      for (int i = 0; i < 56; i++) y[55-i] = x[64-PC1_TAB[i]];
      return y;
   endfunction

   function automatic logic [47:0] perm_pc2(input logic [55:0] x);
      logic [47:0] y;
      for (int i = 0; i < 48; i++) y[47-i] = x[56-PC2_TAB[i]];
      return y;
   endfunction

   function automatic logic [3:0] sbox(input int n, input logic [5:0] x);
      int idx;
      int v;
      idx = 32 * int'(x[5]) + 16 * int'(x[0]) + int'(x[4:1]);
      case (n)
         0:       v = SB1[idx];
         1:       v = SB2[idx];
         2:       v = SB3[idx];
         3:       v = SB4[idx];
         4:       v = SB5[idx];
         5:       v = SB6[idx];
         6:       v = SB7[idx];
         default: v = SB8[idx];
      endcase
      return 4'(v);
   endfunction

endpackage

// File: rtl/des_key_sched.sv
module des_key_sched #(
   parameter int KEY_W  = 64,
   parameter int KH_W   = 28,
   parameter int RK_W   = 48
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              load_en,
   input  logic [KEY_W-1:0]  key_in,
   input  logic              step_en,
   input  logic              dec,
   input  logic              dbl,
   output logic [RK_W-1:0]   round_key,
   output logic [KH_W-1:0]   c_o,
   output logic [KH_W-1:0]   d_o
);
   localparam int CD_W = 2 * KH_W;

   if (KEY_W != 64 || KH_W != 28 || RK_W != 48) begin : g_bad_geometry
      $error("des_key_sched: geometry must be 64/28/48");
   end

   logic [KH_W-1:0] c_q, d_q;
   logic [KH_W-1:0] c_left, d_left, c_right, d_right;
   logic [CD_W-1:0] pc1_out;

   assign pc1_out = des_pkg::perm_pc1(key_in);

   always_comb begin
      if (dbl) begin
         c_left  = {c_q[KH_W-3:0], c_q[KH_W-1:KH_W-2]};
         d_left  = {d_q[KH_W-3:0], d_q[KH_W-1:KH_W-2]};
         c_right = {c_q[1:0], c_q[KH_W-1:2]};
         d_right = {d_q[1:0], d_q[KH_W-1:2]};
      end else begin
         c_left  = {c_q[KH_W-2:0], c_q[KH_W-1]};
         d_left  = {d_q[KH_W-2:0], d_q[KH_W-1]};
         c_right = {c_q[0], c_q[KH_W-1:1]};
         d_right = {d_q[0], d_q[KH_W-1:1]};
      end
   end

   // Encrypt keys come from the rotated halves, decrypt keys from the current ones.
   assign round_key = dec ? des_pkg::perm_pc2({c_q, d_q})
                          : des_pkg::perm_pc2({c_left, d_left});

   always_ff @(posedge clk) begin
      if (rst) begin
         c_q <= '0;
         d_q <= '0;
      end else if (load_en) begin
         c_q <= pc1_out[CD_W-1:KH_W];
         d_q <= pc1_out[KH_W-1:0];
      end else if (step_en) begin
         c_q <= dec ? c_right : c_left;
         d_q <= dec ? d_right : d_left;
      end
   end

   assign c_o = c_q;
   assign d_o = d_q;
endmodule

// File: rtl/des_feistel.sv
module des_feistel #(
   parameter int HALF_W = 32,
   parameter int RK_W   = 48,
   parameter int N_BOX  = 8
) (
   input  logic [HALF_W-1:0] r_in,
   input  logic [RK_W-1:0]   key_in,
   output logic [HALF_W-1:0] f_out
);
   localparam int IN_PER  = RK_W / N_BOX;
   localparam int OUT_PER = HALF_W / N_BOX;

   if (IN_PER != 6 || OUT_PER != 4) begin : g_bad_split
      $error("des_feistel: boxes must map 6 bits to 4 bits");
   end

   logic [RK_W-1:0]   mixed;
   logic [HALF_W-1:0] sub;

   assign mixed = des_pkg::perm_e(r_in) ^ key_in;

   for (genvar g = 0; g < N_BOX; g++) begin : g_box
      assign sub[HALF_W-1-OUT_PER*g -: OUT_PER] =
         des_pkg::sbox(g, mixed[RK_W-1-IN_PER*g -: IN_PER]);
   end

   assign f_out = des_pkg::perm_p(sub);
endmodule

// File: rtl/des_round_unit.sv
module des_round_unit #(
   parameter int WORD_W = 32,
   parameter int OPC_W  = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              valid_i,
   input  logic [OPC_W-1:0]  opc_i,
   input  logic [WORD_W-1:0] op_a_i,
   input  logic [WORD_W-1:0] op_b_i,
   output logic [WORD_W-1:0] result_o
);
   import des_pkg::*;

   localparam int DW = 2 * WORD_W;

   if (WORD_W != HALF_W || OPC_W != 2) begin : g_bad_ports
      $error("des_round_unit: WORD_W must be 32 and OPC_W 2");
   end

   op_e               op;
   logic              do_key, do_data, do_round, do_read;
   logic [WORD_W-1:0] l_q, r_q, f_val, result_q;
   logic [RK_W-1:0]   rkey;
   logic [KH_W-1:0]   key_c, key_d;
   logic [DW-1:0]     ip_out, fp_out;

   assign op       = op_e'(opc_i);
   assign do_key   = valid_i && (op == OP_KEY);
   assign do_data  = valid_i && (op == OP_DATA);
   assign do_round = valid_i && (op == OP_ROUND);
   assign do_read  = valid_i && (op == OP_READ);

   des_key_sched #(.KEY_W(DW), .KH_W(KH_W), .RK_W(RK_W)) u_ks (
      .clk       (clk),
      .rst       (rst),
      .load_en   (do_key),
      .key_in    ({op_a_i, op_b_i}),
      .step_en   (do_round),
      .dec       (op_a_i[0]),
      .dbl       (op_a_i[1]),
      .round_key (rkey),
      .c_o       (key_c),
      .d_o       (key_d)
   );

   des_feistel #(.HALF_W(WORD_W), .RK_W(RK_W), .N_BOX(8)) u_f (
      .r_in   (r_q),
      .key_in (rkey),
      .f_out  (f_val)
   );

   assign ip_out = perm_ip({op_a_i, op_b_i});
   assign fp_out = perm_fp({r_q, l_q});

   always_ff @(posedge clk) begin
      if (rst) begin
         l_q      <= '0;
         r_q      <= '0;
         result_q <= '0;
      end else begin
         if (do_data) begin
            l_q <= ip_out[DW-1:WORD_W];
            r_q <= ip_out[WORD_W-1:0];
         end else if (do_round) begin
            l_q <= r_q;
            r_q <= l_q ^ f_val;
         end
         if (do_read)
            result_q <= op_a_i[0] ? fp_out[DW-1:WORD_W] : fp_out[WORD_W-1:0];
      end
   end

   assign result_o = result_q;
endmodule

// File: rtl/des_round_unit_chk.sv
module des_round_unit_chk (
   input logic        clk,
   input logic        rst,
   input logic        valid_i,
   input logic [1:0]  opc_i,
   input logic [1:0]  flag_i,
   input logic [31:0] result_o,
   input logic [31:0] l_q,
   input logic [31:0] r_q,
   input logic [27:0] key_c,
   input logic [27:0] key_d
);
   import des_pkg::*;

   logic is_round;
   assign is_round = valid_i && (opc_i == OP_ROUND);

   // R8: no strobe, no change anywhere
   p_idle_hold_r8: assert property (@(posedge clk) disable iff (rst)
      !valid_i |=> ($stable(l_q) && $stable(r_q) && $stable(key_c)
                    && $stable(key_d) && $stable(result_o)));

   // R9: only a read may change the result word
   p_result_hold_r9: assert property (@(posedge clk) disable iff (rst)
      (valid_i && opc_i != OP_READ) |=> $stable(result_o));

   // R2: a key load leaves the data halves alone
   p_key_keeps_data_r2: assert property (@(posedge clk) disable iff (rst)
      (valid_i && opc_i == OP_KEY) |=> ($stable(l_q) && $stable(r_q)));

   // R4: the new left half is the previous right half
   p_round_swap_r4: assert property (@(posedge clk) disable iff (rst)
      is_round |=> (l_q == $past(r_q)));

   // R5: encrypt single step rotates C left by one
   p_enc_rotate_r5: assert property (@(posedge clk) disable iff (rst)
      (is_round && flag_i == 2'b00) |=> (key_c == {$past(key_c[26:0]), $past(key_c[27])}));

   // R6: decrypt double step rotates D right by two
   p_dec_rotate_r6: assert property (@(posedge clk) disable iff (rst)
      (is_round && flag_i == 2'b11) |=> (key_d == {$past(key_d[1:0]), $past(key_d[27:2])}));
endmodule

bind des_round_unit des_round_unit_chk u_chk (
   .clk      (clk),
   .rst      (rst),
   .valid_i  (valid_i),
   .opc_i    (opc_i),
   .flag_i   (op_a_i[1:0]),
   .result_o (result_o),
   .l_q      (l_q),
   .r_q      (r_q),
   .key_c    (key_c),
   .key_d    (key_d)
);

// File: tb/des_round_unit_bench.sv
`timescale 1ns/1ps
module des_round_unit_bench;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        valid = 1'b0;
   logic [1:0]  opc = 2'b00;
   logic [31:0] op_a = '0;
   logic [31:0] op_b = '0;
   logic [31:0] result;

   int n_checks = 0;
   int n_err    = 0;
   int cyc      = 0;
   bit done     = 1'b0;

   typedef struct {
      logic [31:0] exp;
      string       tag;
   } item_t;
   item_t sbq[$];

   // encrypt shift schedule as "double" flags, round 1 first
   localparam logic [15:0] ENC_DBL = 16'b0011_1111_0111_1110;
   localparam logic [15:0] DEC_DBL = 16'b0111_1110_1111_1100;

   always #2.5 clk = ~clk;

   des_round_unit u_des_round_unit (
      .clk(clk), .rst(rst), .valid_i(valid), .opc_i(opc),
      .op_a_i(op_a), .op_b_i(op_b), .result_o(result));

   task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
      n_checks++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual=%08h expected=%08h", tag, act, exp);
      end
   endtask

   // monitor: a read captured at a posedge is compared at the following negedge
   logic rd_seen = 1'b0;
   always @(posedge clk) rd_seen <= valid && (opc == 2'b11);
   always @(negedge clk) begin
      if (rd_seen) begin
         if (sbq.size() == 0) begin
            n_checks++;
            n_err++;
            $display("FAIL R7: unexpected read, actual=%08h expected=none", result);
         end else begin
            item_t it;
            it = sbq.pop_front();
            check(result, it.exp, it.tag);
         end
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000 && !done) begin
         done = 1'b1;
         n_checks++;
         n_err++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", n_err, n_checks);
         $finish;
      end
   end

   task automatic drive(input logic [1:0] o, input logic [31:0] a, input logic [31:0] b);
      @(negedge clk);
      valid = 1'b1; opc = o; op_a = a; op_b = b;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         valid = 1'b0;
      end
   endtask

   task automatic load_key(input logic [63:0] k);
      drive(2'b00, k[63:32], k[31:0]);
   endtask

   task automatic load_data(input logic [63:0] d);
      drive(2'b01, d[63:32], d[31:0]);
   endtask

   // sixteen rounds; gap inserts a strobe-low round opcode with garbage (R8)
   task automatic run_rounds(input bit dec, input bit gap);
      for (int i = 0; i < 16; i++) begin
         logic dbl;
         dbl = dec ? DEC_DBL[15-i] : ENC_DBL[15-i];
         drive(2'b10, {30'h3FFF_FFFF ^ 30'(i), dbl, dec}, 32'hDEAD_BEEF);
         if (gap && i == 7) begin
            @(negedge clk);
            valid = 1'b0; opc = 2'b10; op_a = 32'h3; op_b = 32'hFFFF_FFFF;
            @(negedge clk);
            valid = 1'b0; opc = 2'b00; op_a = 32'h1234_5678; op_b = 32'h9ABC_DEF0;
         end
      end
   endtask

   task automatic read_pair(input logic [63:0] exp, input string tag);
      item_t hi, lo;
      hi.exp = exp[63:32]; hi.tag = {tag, " hi"};
      lo.exp = exp[31:0];  lo.tag = {tag, " lo"};
      sbq.push_back(hi);
      drive(2'b11, 32'h1, 32'h0);
      sbq.push_back(lo);
      drive(2'b11, 32'h0, 32'h0);
      idle(3);
   endtask

   initial begin
      idle(4);
      rst = 1'b0;
      @(negedge clk);
      check(result, 32'h0, "R1 result after reset");
      read_pair(64'h0, "R1 R7 readout before load");

      // published vector, back-to-back rounds
      load_key(64'h1334_5779_9BBC_DFF1);
      load_data(64'h0123_4567_89AB_CDEF);
      run_rounds(1'b0, 1'b0);
      read_pair(64'h85E8_1354_0F0A_B405, "R2 R3 R4 R5 R10 encrypt");

      // result must stay at the last word read through loads
      load_key(64'h0);
      load_data(64'hFFFF_FFFF_FFFF_FFFF);
      idle(2);
      check(result, 32'h0F0A_B405, "R9 hold across loads");

      load_key(64'h1334_5779_9BBC_DFF1);
      load_data(64'h85E8_1354_0F0A_B405);
      run_rounds(1'b1, 1'b0);
      read_pair(64'h0123_4567_89AB_CDEF, "R6 decrypt");

      // all-zero key and block
      load_key(64'h0);
      load_data(64'h0);
      run_rounds(1'b0, 1'b0);
      read_pair(64'h8CA6_4DE9_C1B1_23A7, "R5 zero vector encrypt");
      load_data(64'h8CA6_4DE9_C1B1_23A7);
      run_rounds(1'b1, 1'b0);
      read_pair(64'h0, "R6 zero vector decrypt");

      // weak key, with strobe-low cycles in the middle of the sequence
      load_key(64'h0101_0101_0101_0101);
      load_data(64'h95F8_A5E5_DD31_D900);
      run_rounds(1'b0, 1'b1);
      read_pair(64'h8000_0000_0000_0000, "R8 weak key encrypt with idle gap");
      load_data(64'h8000_0000_0000_0000);
      run_rounds(1'b1, 1'b1);
      read_pair(64'h95F8_A5E5_DD31_D900, "R8 weak key decrypt with idle gap");

      if (sbq.size() != 0) begin
         n_checks++;
         n_err++;
         $display("FAIL R7: actual=%0d pending expected=0 pending", sbq.size());
      end
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", n_err, n_checks);
         $finish;
      end
   end
endmodule